// File: doc/BRIEF.md
# Indexed Voice Register Window

This block is the host-facing register window of a multi-voice synthesizer. The host picks a voice with a voice-select byte and a register with a function-select byte, then moves 16-bit values through a data port. The data port can be used as one 16-bit word or as two separate byte lanes. Each voice owns fourteen 16-bit registers in an internal register RAM. The word address of that RAM is formed from both select bytes. A few function codes reach global state instead: an active-voice count, a global reset/run register, and a 20-bit pointer into sample memory.

A separate byte port reads and writes sample memory at the pointer. The pointer does not advance on its own. The host bus is synchronous. A write takes effect at the clock edge where the write strobe is high. Read data appears on the cycle after the read strobe and holds until the next read.

Host port addresses: 0 is voice select, 1 is function select, 2 is the data low lane, 3 is the data high lane, 4 is the sample-memory byte. Addresses 5 to 7 are unmapped. `host_wide` = 1 marks a 16-bit access. A byte write always carries its byte on `host_wdata[7:0]`.

Top module: `voice_reg_window`

## Requirements
- R1: After reset, the voice select and the function select both read back 0, the active-voice count reads 0x00CD, and per-voice writes are disarmed because bit 0 of the global reset register is 0.
- R2: A write to port 0 or port 1 stores `host_wdata[7:0]`. A read of that port returns the byte zero-extended to 16 bits.
- R3: With bit 0 of the global register set, a word write with function code f in 0x00..0x0D stores a word at RAM word (voice & 0x1F)*16 + f. A read with code 0x80|f returns that word. Voice bits above bit 4 are ignored.
- R4: A byte write to port 2 with a per-voice code replaces bits 7:0 of the selected word and keeps bits 15:8.
- R5: A byte write to port 3 with a per-voice code places the byte in bits 15:8 and keeps bits 7:0.
- R6: A byte read of port 2 returns {0x00, bits 7:0}. A byte read of port 3 returns {0x00, bits 15:8}. A word read on either data port returns all 16 bits.
- R7: While bit 0 of the global register (written with code 0x4C) is 0, per-voice writes leave the register RAM unchanged.
- R8: Code 0x0E writes the active-voice count and code 0x8E reads it as {0x00, count}. A 0x4C write with bit 0 clear restores the count to 0xCD.
- R9: Code 0x43 loads pointer bits 15:0 with the same lane merging as R4/R5. Code 0x44 loads pointer bits 19:16 from `host_wdata[3:0]` and keeps bits 15:0.
- R10: A port 4 write stores `host_wdata[7:0]` at the pointer, and a port 4 read returns {0x00, byte}. Accesses never move the pointer.
- R11: A data port read with any code other than 0x80..0x8E returns 0xFFFF. A read of ports 5..7 also returns 0xFFFF.
- R12: Read data changes only in the cycle after a read strobe and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Port address (0..4 mapped) |
| host_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 16 | Write data; bytes on bits 7:0 |
| host_rdata | output | 16 | Read data, valid the cycle after `host_rd` |

## Verification
The assertions assume the host never raises the read and write strobes in the same cycle, and that the port address is stable whenever a strobe is high. The stimulus tasks drive exactly one strobe per access on the falling edge and drop it one cycle later, so both assumptions hold. The register sweep covers every voice and every per-voice code at the default width. Byte-lane and pointer cases start from word values the bench has already written, so every merge result is known in advance.

// File: rtl/voice_win_pkg.sv
package voice_win_pkg;

    typedef enum logic [2:0] {
        PA_VSEL = 3'd0,
        PA_FSEL = 3'd1,
        PA_DLO  = 3'd2,
        PA_DHI  = 3'd3,
        PA_SMEM = 3'd4
    } port_e;

    localparam logic [7:0] FN_COUNT_WR = 8'h0E;
    localparam logic [7:0] FN_COUNT_RD = 8'h8E;
    localparam logic [7:0] FN_PTR_LO   = 8'h43;
    localparam logic [7:0] FN_PTR_TOP  = 8'h44;
    localparam logic [7:0] FN_GRESET   = 8'h4C;
    localparam logic [3:0] FN_VOICE_MAX = 4'hD;
    localparam logic [3:0] FN_RD_GROUP  = 4'h8;
    localparam logic [7:0] COUNT_INIT  = 8'hCD;

    typedef enum logic [2:0] {
        SRC_ONES,
        SRC_VSEL,
        SRC_FSEL,
        SRC_VOICE,
        SRC_COUNT,
        SRC_SMEM
    } rsrc_e;

    typedef struct packed {
        logic vsel;
        logic fsel;
        logic voice_lo;
        logic voice_hi;
        logic count;
        logic greset;
        logic ptr_lo;
        logic ptr_mid;
        logic ptr_top;
        logic smem;
    } wr_ctl_t;

endpackage

// File: rtl/voice_win_decode.sv
module voice_win_decode
    import voice_win_pkg::*;
(
    input  logic [2:0]  addr,
    input  logic        wide,
    input  logic        wr,
    input  logic [7:0]  fsel,
    input  logic        arm,
    input  logic [15:0] wdata,
    output wr_ctl_t     ctl,
    output rsrc_e       src,
    output logic        hi_lane,
    output logic [15:0] lane_data
);

    logic is_lo, is_hi, is_data, lane_lo, lane_hi;
    logic voice_wr_fn, voice_rd_fn;

    always_comb begin
        is_lo   = (addr == PA_DLO);
        is_hi   = (addr == PA_DHI);
        is_data = is_lo | is_hi;
        lane_lo = is_data && (wide || is_lo);
        lane_hi = is_data && (wide || is_hi);
        hi_lane = is_hi && !wide;

        if (wide)       lane_data = wdata;
        else if (is_hi) lane_data = {wdata[7:0], 8'h00};
        else            lane_data = {8'h00, wdata[7:0]};

        voice_wr_fn = (fsel[7:4] == 4'h0) && (fsel[3:0] <= FN_VOICE_MAX);
        voice_rd_fn = (fsel[7:4] == FN_RD_GROUP) && (fsel[3:0] <= FN_VOICE_MAX);

        ctl = '0;
        if (wr) begin
            ctl.vsel     = (addr == PA_VSEL);
            ctl.fsel     = (addr == PA_FSEL);
            ctl.voice_lo = lane_lo && voice_wr_fn && arm;
            ctl.voice_hi = lane_hi && voice_wr_fn && arm;
            ctl.count    = is_data && (fsel == FN_COUNT_WR);
            ctl.greset   = is_data && (fsel == FN_GRESET);
            ctl.ptr_lo   = lane_lo && (fsel == FN_PTR_LO);
            ctl.ptr_mid  = lane_hi && (fsel == FN_PTR_LO);
            ctl.ptr_top  = is_data && (fsel == FN_PTR_TOP);
            ctl.smem     = (addr == PA_SMEM);
        end

        case (addr)
            PA_VSEL: src = SRC_VSEL;
            PA_FSEL: src = SRC_FSEL;
            PA_DLO, PA_DHI: begin
                if (voice_rd_fn)               src = SRC_VOICE;
                else if (fsel == FN_COUNT_RD)  src = SRC_COUNT;
                else                           src = SRC_ONES;
            end
            PA_SMEM: src = SRC_SMEM;
            default: src = SRC_ONES;
        endcase
    end

endmodule

// File: rtl/voice_win_regram.sv
module voice_win_regram #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata
);

    localparam int DEPTH = 1 << AW;

    logic [1:0] lane_we;
    assign lane_we = {we_hi, we_lo};

    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic [7:0] mem_q [DEPTH];
        always_ff @(posedge clk) begin
            if (lane_we[l]) mem_q[addr] <= wdata[l*8 +: 8];
        end
        assign rdata[l*8 +: 8] = mem_q[addr];
    end

endmodule

// File: rtl/voice_win_smem.sv
module voice_win_smem #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/voice_reg_window.sv
module voice_reg_window
    import voice_win_pkg::*;
#(
    parameter int VOICE_BITS = 5,
    parameter int PTR_W      = 20,
    parameter int SMEM_AW    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  host_addr,
    input  logic        host_wide,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata
);

    localparam int RAM_AW = VOICE_BITS + 4;
    localparam int TOP_W  = PTR_W - 16;

    typedef struct packed {
        logic [7:0]       vsel;
        logic [7:0]       fsel;
        logic [7:0]       count;
        logic [7:0]       greset;
        logic [PTR_W-1:0] ptr;
        logic [15:0]      rdata;
    } st_t;

    st_t cur_q, nxt_d;

    wr_ctl_t     ctl;
    rsrc_e       src;
    logic        hi_lane;
    logic [15:0] lane_data;
    logic [15:0] voice_word;
    logic [7:0]  smem_byte;
    logic        voice_we;

    voice_win_decode dec_i (
        .addr      (host_addr),
        .wide      (host_wide),
        .wr        (host_wr),
        .fsel      (cur_q.fsel),
        .arm       (cur_q.greset[0]),
        .wdata     (host_wdata),
        .ctl       (ctl),
        .src       (src),
        .hi_lane   (hi_lane),
        .lane_data (lane_data)
    );

    voice_win_regram #(.AW(RAM_AW)) regram_i (
        .clk   (clk),
        .addr  ({cur_q.vsel[VOICE_BITS-1:0], cur_q.fsel[3:0]}),
        .we_lo (ctl.voice_lo),
        .we_hi (ctl.voice_hi),
        .wdata (lane_data),
        .rdata (voice_word)
    );

    voice_win_smem #(.AW(SMEM_AW)) smem_i (
        .clk   (clk),
        .addr  (cur_q.ptr[SMEM_AW-1:0]),
        .we    (ctl.smem),
        .wdata (host_wdata[7:0]),
        .rdata (smem_byte)
    );

    assign voice_we = ctl.voice_lo | ctl.voice_hi;

    always_comb begin
        nxt_d = cur_q;

        if (ctl.vsel)  nxt_d.vsel  = host_wdata[7:0];
        if (ctl.fsel)  nxt_d.fsel  = host_wdata[7:0];
        if (ctl.count) nxt_d.count = host_wdata[7:0];
        if (ctl.greset) begin
            nxt_d.greset = host_wdata[7:0];
            if (!host_wdata[0]) nxt_d.count = COUNT_INIT;
        end

        if (ctl.ptr_lo)  nxt_d.ptr[7:0]        = lane_data[7:0];
        if (ctl.ptr_mid) nxt_d.ptr[15:8]       = lane_data[15:8];
        if (ctl.ptr_top) nxt_d.ptr[PTR_W-1:16] = host_wdata[TOP_W-1:0];

        if (host_rd) begin
            case (src)
                SRC_VSEL:  nxt_d.rdata = {8'h00, cur_q.vsel};
                SRC_FSEL:  nxt_d.rdata = {8'h00, cur_q.fsel};
                SRC_COUNT: nxt_d.rdata = {8'h00, cur_q.count};
                SRC_SMEM:  nxt_d.rdata = {8'h00, smem_byte};
                SRC_VOICE: begin
                    if (host_wide)    nxt_d.rdata = voice_word;
                    else if (hi_lane) nxt_d.rdata = {8'h00, voice_word[15:8]};
                    else              nxt_d.rdata = {8'h00, voice_word[7:0]};
                end
                default:   nxt_d.rdata = 16'hFFFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q        <= '0;
            cur_q.count  <= COUNT_INIT;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign host_rdata = cur_q.rdata;

endmodule

// File: rtl/voice_win_checker.sv
module voice_win_checker #(
    parameter int PTR_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       host_addr,
    input logic             host_wr,
    input logic             host_rd,
    input logic [15:0]      host_wdata,
    input logic [15:0]      host_rdata,
    input logic [7:0]       vsel,
    input logic [7:0]       fsel,
    input logic [7:0]       count,
    input logic             arm,
    input logic [PTR_W-1:0] ptr,
    input logic             voice_we
);

    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> ($stable(vsel) && $stable(fsel)));

    assert_voice_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        voice_we |-> arm);

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(count));

    assert_ptr_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (host_addr == 3'd2 || host_addr == 3'd3) && fsel == 8'h44)
        |=> (ptr[PTR_W-1:16] == $past(host_wdata[PTR_W-17:0])));

    assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(ptr));

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr > 3'd4) |=> (host_rdata == 16'hFFFF));

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

endmodule

bind voice_reg_window voice_win_checker #(.PTR_W(PTR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .vsel       (cur_q.vsel),
    .fsel       (cur_q.fsel),
    .count      (cur_q.count),
    .arm        (cur_q.greset[0]),
    .ptr        (cur_q.ptr),
    .voice_we   (voice_we)
);

// File: tb/voice_reg_window_tb.sv
module voice_reg_window_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wide = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] model [512];
    logic [7:0]  smodel [256];

    always #4 clk = ~clk;

    voice_reg_window dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wide(host_wide),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    task automatic wr(input logic [2:0] a, input logic w, input logic [15:0] d);
        host_addr = a; host_wide = w; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic w, output logic [15:0] v);
        host_addr = a; host_wide = w; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int v, input int f);
        return 16'((v * 16'h0123 + f * 16'h1111) ^ 16'h5A5A);
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, 1'b0, v); chk("R1 vsel", v, 16'h0000);
        rd(3'd1, 1'b0, v); chk("R1 fsel", v, 16'h0000);
        wr(3'd1, 1'b0, 16'h008E);
        rd(3'd2, 1'b1, v); chk("R1 count", v, 16'h00CD);
        // R1/R7 disarmed: write then read voice 0 fn 0 stays unwritten is unknown, check via arm later

        // R2 select round trip
        wr(3'd0, 1'b0, 16'hAB37);
        rd(3'd0, 1'b1, v); chk("R2 vsel", v, 16'h0037);
        wr(3'd1, 1'b0, 16'hFF5C);
        rd(3'd1, 1'b0, v); chk("R2 fsel", v, 16'h005C);

        // arm per-voice writes
        wr(3'd1, 1'b0, 16'h004C);
        wr(3'd2, 1'b1, 16'h0001);

        // R3 sweep over all voices and per-voice codes
        for (int vo = 0; vo < 32; vo++) begin
            wr(3'd0, 1'b0, 16'(vo));
            for (int f = 0; f < 14; f++) begin
                wr(3'd1, 1'b0, 16'(f));
                wr(3'd2, 1'b1, pat(vo, f));
                model[vo*16 + f] = pat(vo, f);
            end
        end
        for (int vo = 0; vo < 32; vo++) begin
            wr(3'd0, 1'b0, 16'(vo));
            for (int f = 0; f < 14; f++) begin
                wr(3'd1, 1'b0, 16'(8'h80 | f));
                rd(3'd2, 1'b1, v); chk("R3 sweep", v, model[vo*16 + f]);
            end
        end
        // R3 upper voice bits ignored
        wr(3'd0, 1'b0, 16'h00E5);
        wr(3'd1, 1'b0, 16'h0087);
        rd(3'd2, 1'b1, v); chk("R3 alias", v, model[5*16 + 7]);

        // R4/R5 byte-lane merges on voice 3 fn 2
        wr(3'd0, 1'b0, 16'h0003);
        wr(3'd1, 1'b0, 16'h0002);
        wr(3'd2, 1'b0, 16'h77AB);
        model[3*16 + 2] = {model[3*16 + 2][15:8], 8'hAB};
        wr(3'd1, 1'b0, 16'h0082);
        rd(3'd2, 1'b1, v); chk("R4 low lane", v, model[3*16 + 2]);
        wr(3'd1, 1'b0, 16'h0002);
        wr(3'd3, 1'b0, 16'h11CD);
        model[3*16 + 2] = {8'hCD, model[3*16 + 2][7:0]};
        wr(3'd1, 1'b0, 16'h0082);
        rd(3'd3, 1'b1, v); chk("R5 high lane", v, model[3*16 + 2]);

        // R6 byte reads
        rd(3'd2, 1'b0, v); chk("R6 lo read", v, {8'h00, model[3*16 + 2][7:0]});
        rd(3'd3, 1'b0, v); chk("R6 hi read", v, {8'h00, model[3*16 + 2][15:8]});

        // R8 count write and read
        wr(3'd1, 1'b0, 16'h000E);
        wr(3'd2, 1'b0, 16'h0012);
        wr(3'd1, 1'b0, 16'h008E);
        rd(3'd2, 1'b1, v); chk("R8 count", v, 16'h0012);

        // R7/R8 disarm restores count and blocks voice writes
        wr(3'd1, 1'b0, 16'h004C);
        wr(3'd2, 1'b1, 16'h0000);
        wr(3'd1, 1'b0, 16'h008E);
        rd(3'd2, 1'b1, v); chk("R8 count restore", v, 16'h00CD);
        wr(3'd1, 1'b0, 16'h0002);
        wr(3'd2, 1'b1, 16'hDEAD);
        wr(3'd3, 1'b0, 16'h0099);
        wr(3'd1, 1'b0, 16'h0082);
        rd(3'd2, 1'b1, v); chk("R7 blocked", v, model[3*16 + 2]);

        // R11 unsupported codes and ports
        wr(3'd1, 1'b0, 16'h0050);
        rd(3'd2, 1'b1, v); chk("R11 fn 0x50", v, 16'hFFFF);
        wr(3'd1, 1'b0, 16'h0005);
        rd(3'd3, 1'b0, v); chk("R11 fn 0x05", v, 16'hFFFF);
        wr(3'd1, 1'b0, 16'h0043);
        rd(3'd2, 1'b1, v); chk("R11 fn 0x43", v, 16'hFFFF);
        rd(3'd6, 1'b1, v); chk("R11 port 6", v, 16'hFFFF);

        // R12 hold without strobe
        repeat (3) @(negedge clk);
        wr(3'd4, 1'b0, 16'h0000);
        chk("R12 hold", host_rdata, 16'hFFFF);

        // R9/R10 pointer and sample memory sweep
        for (int i = 0; i < 16; i++) begin
            wr(3'd1, 1'b0, 16'h0043);
            wr(3'd2, 1'b1, 16'(i * 17 + 16'h3100));
            wr(3'd1, 1'b0, 16'h0044);
            wr(3'd2, 1'b0, 16'(i));
            wr(3'd4, 1'b0, 16'(8'hC0 ^ i));
            smodel[(i * 17) % 256] = 8'(8'hC0 ^ i);
        end
        for (int i = 0; i < 16; i++) begin
            wr(3'd1, 1'b0, 16'h0043);
            wr(3'd2, 1'b1, 16'(i * 17));
            rd(3'd4, 1'b0, v); chk("R10 sweep", v, {8'h00, smodel[(i * 17) % 256]});
            rd(3'd4, 1'b1, v); chk("R10 no increment", v, {8'h00, smodel[(i * 17) % 256]});
        end
        // R9 low lane byte load keeps upper byte, 0x44 keeps low 16
        wr(3'd1, 1'b0, 16'h0043);
        wr(3'd2, 1'b1, 16'h1200);
        wr(3'd2, 1'b0, 16'h0056);
        wr(3'd4, 1'b0, 16'h0099);
        wr(3'd3, 1'b0, 16'h0000);
        wr(3'd1, 1'b0, 16'h0044);
        wr(3'd3, 1'b0, 16'h000F);
        rd(3'd4, 1'b0, v); chk("R9 lane and top load", v, 16'h0099);
        wr(3'd1, 1'b0, 16'h0043);
        wr(3'd3, 1'b0, 16'h0001);
        rd(3'd4, 1'b0, v); chk("R9 high lane keeps low", v, 16'h0099);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule